// File: doc/BRIEF.md
# General-Purpose I/O Port with Pin Interrupts

A 32-pin general-purpose I/O port on a simple word-wide register bus. Software picks per pin whether the port drives it or listens to it, writes output values, and reads back pin levels. Each input passes through a two-flop synchronizer. The synchronized level then feeds a per-pin detector that can match a low level, a high level, a rising edge or a falling edge.

When a detector matches, the pin's bit in a sticky status register is set. A software write of one to that bit clears it. A mask register gates the status bits, and any unmasked pending bit raises the single interrupt output. The bus has one write strobe and a byte address. Reads are combinational from the address.

Register map (byte offsets, 32-bit words):

| Offset | Register | Contents |
|---|---|---|
| 0x00 | data | output values on write; pin levels on read |
| 0x04 | direction | 1 = output, 0 = input |
| 0x08 | lower mode | modes for pins 0..15 |
| 0x0C | upper mode | modes for pins 16..31 |
| 0x10 | mask | 1 = interrupt enabled |
| 0x14 | status | write one to clear |

Top module: `gpio_port`

## Requirements
- R1: While rst_ni is low, pin_o, pin_oe_o and irq_o are 0, and the direction, mask and mode registers read 0.
- R2: pin_oe_o equals the direction register at offset 0x04, one bit per pin, where 1 selects output. It takes the written value on the clock edge of the write.
- R3: A write to offset 0x00 sets pin_o. A read of 0x00 returns, per pin, the data register where the direction bit is 1. Where the direction bit is 0, it returns the pin input delayed by a two-flop synchronizer, so a pin change shows after two clock edges and not after one.
- R4: Pin n's 2-bit mode sits at bits [2(n mod 16)+1 : 2(n mod 16)] of offset 0x08 for pins 0..15, or of offset 0x0C for pins 16..31. Both registers read back what was written.
- R5: Mode encodings are 00 = low level, 01 = high level, 10 = rising edge, 11 = falling edge. A matching condition on the synchronized pin sets that pin's status bit (offset 0x14).
- R6: An edge mode sets status once per transition. The bit stays set after the pin settles and is not set again while the pin holds its level, nor by the opposite transition.
- R7: Writing offset 0x14 clears each status bit written as 1 and leaves bits written as 0 unchanged.
- R8: If a detection and a clear of the same bit fall in the same cycle, the bit stays set, so a level condition that is still present cannot be cleared.
- R9: Status bits are set whatever the mask (offset 0x10) holds. irq_o is high exactly when status AND mask is non-zero, and the mask resets to 0.
- R10: Reads of offsets outside the map return 0, and writes to them change nothing visible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous active-low reset |
| bus_we_i | input | 1 | write strobe |
| bus_addr_i | input | 5 | byte address of the word |
| bus_wdata_i | input | 32 | write data |
| bus_rdata_o | output | 32 | read data for bus_addr_i |
| pin_i | input | 32 | pin input levels |
| pin_o | output | 32 | pin output values |
| pin_oe_o | output | 32 | pin output enables |
| irq_o | output | 1 | combined interrupt |

## Verification
The bench clears a level-mode bit while its pin still holds the level. A design where the clear beats the set would show the bit gone. It drops and re-holds edge pins to catch a detector that compares raw levels and so acts like a level mode, and it drives the opposite transition to catch swapped rise and fall encodings. It samples a pin change after one edge and after two, which exposes a missing or doubled synchronizer stage. Partial clears check that a clear touches only the bits written as one.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [1:0] {
    TRIG_LOW  = 2'b00,
    TRIG_HIGH = 2'b01,
    TRIG_RISE = 2'b10,
    TRIG_FALL = 2'b11
  } trig_e;

  localparam int unsigned ADDR_W = 5;
  localparam logic [ADDR_W-1:0] OFS_DATA   = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_DIR    = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_CFG_LO = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_CFG_HI = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_MASK   = 5'h10;
  localparam logic [ADDR_W-1:0] OFS_STAT   = 5'h14;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
    end
  end

  assign sync_o = sync_q;

  // R3: exactly two stages of latency
  a_r3_sync_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(rst_ni, 2)) |-> (sync_o == $past(async_i, 2)));
endmodule

// File: rtl/gpio_detect.sv
module gpio_detect
  import gpio_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [WIDTH-1:0]   level_i,
  input  logic [2*WIDTH-1:0] mode_i,
  output logic [WIDTH-1:0]   hit_o
);
  logic [WIDTH-1:0] last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= '0;
    else         last_q <= level_i;
  end

  for (genvar n = 0; n < WIDTH; n++) begin : g_pin
    trig_e mode;
    assign mode = trig_e'(mode_i[2*n +: 2]);
    always_comb begin
      unique case (mode)
        TRIG_LOW:  hit_o[n] = ~level_i[n];
        TRIG_HIGH: hit_o[n] =  level_i[n];
        TRIG_RISE: hit_o[n] =  level_i[n] & ~last_q[n];
        default:   hit_o[n] = ~level_i[n] &  last_q[n];
      endcase
    end

    // R6: an edge hit lasts a single cycle while the level holds
    a_r6_edge_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hit_o[n] && mode_i[2*n+1] && $stable(mode_i[2*n +: 2])) |=> (!hit_o[n] || !$stable(level_i[n])));
  end
endmodule

// File: rtl/gpio_status.sv
module gpio_status #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] hit_i,
  input  logic [WIDTH-1:0] clr_i,
  input  logic [WIDTH-1:0] mask_i,
  output logic [WIDTH-1:0] stat_o,
  output logic             irq_o
);
  logic [WIDTH-1:0] stat_q;

  // set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= (stat_q & ~clr_i) | hit_i;
  end

  assign stat_o = stat_q;
  assign irq_o  = |(stat_q & mask_i);

  a_r8_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|hit_i) |=> ((stat_o & $past(hit_i)) == $past(hit_i)));

  a_r7_clear_takes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|clr_i) |=> ((stat_o & $past(clr_i) & ~$past(hit_i)) == '0));

  a_r9_irq_when_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(hit_i & mask_i) && $stable(mask_i)) |=> (irq_o || !$stable(mask_i)));
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int unsigned PINS = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [PINS-1:0]   bus_wdata_i,
  output logic [PINS-1:0]   bus_rdata_o,
  input  logic [PINS-1:0]   pin_i,
  output logic [PINS-1:0]   pin_o,
  output logic [PINS-1:0]   pin_oe_o,
  output logic              irq_o
);
  localparam int unsigned CFG_PINS = PINS / 2;

  logic [PINS-1:0] data_q, dir_q, cfg_lo_q, cfg_hi_q, mask_q;
  logic [PINS-1:0] level, hit, stat, clr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q   <= '0;
      dir_q    <= '0;
      cfg_lo_q <= '0;
      cfg_hi_q <= '0;
      mask_q   <= '0;
    end else if (bus_we_i) begin
      unique case (bus_addr_i)
        OFS_DATA:   data_q   <= bus_wdata_i;
        OFS_DIR:    dir_q    <= bus_wdata_i;
        OFS_CFG_LO: cfg_lo_q <= bus_wdata_i;
        OFS_CFG_HI: cfg_hi_q <= bus_wdata_i;
        OFS_MASK:   mask_q   <= bus_wdata_i;
        default: ;
      endcase
    end
  end

  assign clr = (bus_we_i && bus_addr_i == OFS_STAT) ? bus_wdata_i : '0;

  gpio_sync #(.WIDTH(PINS)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (pin_i),
    .sync_o  (level)
  );

  gpio_detect #(.WIDTH(PINS)) u_detect (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .level_i (level),
    .mode_i  ({cfg_hi_q[2*CFG_PINS-1:0], cfg_lo_q[2*CFG_PINS-1:0]}),
    .hit_o   (hit)
  );

  gpio_status #(.WIDTH(PINS)) u_status (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hit_i  (hit),
    .clr_i  (clr),
    .mask_i (mask_q),
    .stat_o (stat),
    .irq_o  (irq_o)
  );

  always_comb begin
    unique case (bus_addr_i)
      OFS_DATA:   bus_rdata_o = (data_q & dir_q) | (level & ~dir_q);
      OFS_DIR:    bus_rdata_o = dir_q;
      OFS_CFG_LO: bus_rdata_o = cfg_lo_q;
      OFS_CFG_HI: bus_rdata_o = cfg_hi_q;
      OFS_MASK:   bus_rdata_o = mask_q;
      OFS_STAT:   bus_rdata_o = stat;
      default:    bus_rdata_o = '0;
    endcase
  end

  assign pin_o    = data_q;
  assign pin_oe_o = dir_q;

  a_r2_oe_follows_dir: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_addr_i == OFS_DIR) |=> (pin_oe_o == $past(bus_wdata_i)));

  a_r3_data_drives_pins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_addr_i == OFS_DATA) |=> (pin_o == $past(bus_wdata_i)));

  a_r10_unmapped_write_inert: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_addr_i > OFS_STAT) |=> ($stable(pin_o) && $stable(pin_oe_o)));
endmodule

// File: tb/gpio_port_bench.sv
module gpio_port_bench;
  import gpio_pkg::*;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, pin_in = '0, pout, poe;
  logic        irq;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  gpio_port u_gpio_port (
    .clk_i(clk), .rst_ni(rst_ni), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .pin_i(pin_in),
    .pin_o(pout), .pin_oe_o(poe), .irq_o(irq)
  );

  typedef struct packed {
    logic [4:0]  a;
    logic [31:0] d;
    logic [31:0] exp_v;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{5'h04, 32'hFFFF0000, 32'hFFFF0000},  // R2
    '{5'h10, 32'h00F0F0F0, 32'h00F0F0F0},  // R9
    '{5'h08, 32'hDEADBEEF, 32'hDEADBEEF},  // R4
    '{5'h0C, 32'h12345678, 32'h12345678},  // R4
    '{5'h00, 32'hCAFEF00D, 32'hCAFE0000},  // R3 mixed direction, inputs low
    '{5'h04, 32'hFFFFFFFF, 32'hFFFFFFFF},  // R2
    '{5'h00, 32'h0BADBEEF, 32'h0BADBEEF},  // R3
    '{5'h18, 32'hFFFFFFFF, 32'h00000000},  // R10
    '{5'h1C, 32'hFFFFFFFF, 32'h00000000}   // R10
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp_v);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    addr = a;
    #0.5;
    d = rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  logic [31:0] r;
  logic done = 1'b0;

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    idle(3);
    chk("R1 pin_o", pout, 0);
    chk("R1 pin_oe_o", poe, 0);
    chk("R1 irq_o", {31'b0, irq}, 0);
    rd(OFS_MASK, r); chk("R1 mask", r, 0);
    rd(OFS_CFG_LO, r); chk("R1 mode lo", r, 0);
    @(negedge clk); rst_ni = 1'b1;
    idle(4);
    // R9: low-level default sets status on low pins though masked off
    rd(OFS_STAT, r); chk("R9 status unmasked set", r, 32'hFFFFFFFF);
    chk("R9 irq masked", {31'b0, irq}, 0);

    for (int i = 0; i < 9; i++) begin
      wr(VECS[i].a, VECS[i].d);
      rd(VECS[i].a, r);
      chk($sformatf("R10 vector %0d", i), r, VECS[i].exp_v);
    end
    chk("R3 pin_o", pout, 32'h0BADBEEF);
    chk("R2 pin_oe_o", poe, 32'hFFFFFFFF);
    chk("R9 irq from mask", {31'b0, irq}, 1);

    // quiet setup: all inputs, high-level mode, nothing masked
    wr(OFS_MASK, 0);
    wr(OFS_DIR, 0);
    wr(OFS_CFG_LO, 32'h55555555);
    wr(OFS_CFG_HI, 32'h55555555);
    wr(OFS_STAT, 32'hFFFFFFFF);
    rd(OFS_STAT, r); chk("R7 clear all", r, 0);

    // R3: synchronizer latency
    pin_in = 32'h00000100;  // raise pin 8 at a negedge
    @(negedge clk); rd(OFS_DATA, r); chk("R3 one edge old", r, 0);
    @(negedge clk); rd(OFS_DATA, r); chk("R3 two edges new", r, 32'h00000100);
    pin_in = 0; idle(3); wr(OFS_STAT, 32'hFFFFFFFF);

    // R5 high level, R9 mask, R8 set wins
    pin_in[3] = 1'b1; idle(4);
    rd(OFS_STAT, r); chk("R5 high level", r, 32'h00000008);
    chk("R9 masked no irq", {31'b0, irq}, 0);
    wr(OFS_MASK, 32'h00000008);
    chk("R9 unmasked irq", {31'b0, irq}, 1);
    wr(OFS_STAT, 32'h00000008);
    rd(OFS_STAT, r); chk("R8 held level survives clear", r, 32'h00000008);
    pin_in[3] = 1'b0; idle(3);
    wr(OFS_STAT, 32'h00000008);
    rd(OFS_STAT, r); chk("R7 cleared after release", r, 0);
    chk("R9 irq drops", {31'b0, irq}, 0);

    // R4/R6 rising on pin 20 (upper register bits 9:8 = 10)
    wr(OFS_CFG_HI, 32'h55555655);
    // R4/R6 falling on pin 5 (lower register bits 11:10 = 11)
    wr(OFS_CFG_LO, 32'h55555D55);
    wr(OFS_STAT, 32'hFFFFFFFF);
    pin_in[20] = 1'b1; pin_in[5] = 1'b1; idle(4);
    rd(OFS_STAT, r); chk("R6 rise set, fall quiet", r, 32'h00100000);
    wr(OFS_STAT, 32'hFFFFFFFF); idle(3);
    rd(OFS_STAT, r); chk("R6 held high no reset", r, 0);
    pin_in[20] = 1'b0; pin_in[5] = 1'b0; idle(4);
    rd(OFS_STAT, r); chk("R6 fall set, rise quiet", r, 32'h00000020);
    pin_in[20] = 1'b1; idle(4);
    rd(OFS_STAT, r); chk("R6 latched both", r, 32'h00100020);
    wr(OFS_STAT, 32'h00100000);
    rd(OFS_STAT, r); chk("R7 partial clear", r, 32'h00000020);
    wr(OFS_STAT, 32'h00000000);
    rd(OFS_STAT, r); chk("R7 zero write keeps", r, 32'h00000020);

    // R5 low level on pin 0
    wr(OFS_STAT, 32'hFFFFFFFF);
    wr(OFS_CFG_LO, 32'h55555D54);
    idle(2);
    rd(OFS_STAT, r); chk("R5 low level", r, 32'h00000001);

    // R3 mixed read
    wr(OFS_DIR, 32'h0000FFFF);
    wr(OFS_DATA, 32'h12345678);
    pin_in = 32'hABCD0000; idle(3);
    rd(OFS_DATA, r); chk("R3 mixed read", r, 32'hABCD5678);
    chk("R2 oe mixed", poe, 32'h0000FFFF);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule